// File: doc/BRIEF.md
# Register-mapped 32-bit adder peripheral

This block is a small accelerator on an internal register bus. It holds two 32-bit operands and a 32-bit result. It also holds one word that packs a writable control half and a read-only status half. Software loads the two operands, then sets the start bit in the control half. One clock later the block stores the sum of the operands, modulo 2^32, in the result register and raises a done flag in the status half. Software clears the start bit to drop the done flag before it starts the next addition.

The bus is a simple strobe interface. It has a 16-bit byte address, a write strobe with 32-bit write data, and a read strobe. Read data is registered and is valid in the cycle after the read strobe. The upper twelve address bits must equal the peripheral's base value. Address bits [3:2] pick one of four words:

| Index | Word |
|-------|------|
| 0 | operand A |
| 1 | operand B |
| 2 | sum |
| 3 | control/status |

Top module: `sumacc_top`

## Requirements
- R1: An access hits only when address bits [15:4] equal BASE (default 0x321) and address bits [1:0] are zero. A write that misses changes no register. A read that misses returns 0x0000_0000.
- R2: While rst_n is low at a rising clock edge, every register and the read data are cleared. After reset, each of the four words reads 0x0000_0000.
- R3: A write to index 0 or index 1 stores the full 32-bit write data in operand A or operand B. A read of that index returns the stored value.
- R4: A write to index 3 stores write data bits [15:0] as the control half. Write data bits [31:16] are ignored. Index 3 reads as {15 zero bits, done, control[15:0]}.
- R5: When control bit 0 goes from 0 to 1 at a clock edge, the sum register loads (A + B) mod 2^32 at the next edge, and done is set at that same edge. A read placed one cycle earlier still returns the old sum and done = 0.
- R6: Index 2 is read-only. A write to index 2 leaves the sum unchanged.
- R7: A write to index 3 with bit 0 equal to 0 clears done at that write's clock edge. If a start falls on the same edge, the clear takes priority.
- R8: After done is set, writes to operand A or operand B leave the sum unchanged until the next start.
- R9: Read data is registered. It takes the addressed word's value as of the read strobe's clock edge and holds until the next read strobe.
- R10: A write to index 3 with bit 0 equal to 1, while control bit 0 is already 1, starts no new addition. The sum and done stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Byte address: [15:4] peripheral select, [3:2] word index, [1:0] zero |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |

## Verification
The embedded properties assume that all bus inputs are known at every rising edge once reset is released. They also assume that a write and a read never fall in the same cycle, so each cycle carries at most one access. The stimulus holds to this in three ways: it changes inputs only on falling edges, it issues one strobe per cycle, and it keeps every input at a defined value from time zero. Reads that are meant to observe a finished addition wait one idle cycle after the start write. One read is deliberately placed in the gap cycle, to show that the sum and done have not yet changed there.

// File: rtl/sumacc_pkg.sv
// Package: shared word-index encoding for the adder peripheral.
// Assumes a four-word register window indexed by a 2-bit field.
package sumacc_pkg;

    localparam int IDX_W = 2;

    typedef enum logic [IDX_W-1:0] {
        IDX_OPA = 2'd0,
        IDX_OPB = 2'd1,
        IDX_SUM = 2'd2,
        IDX_CSR = 2'd3
    } reg_idx_e;

endpackage

// File: rtl/sumacc_decode.sv
// Module: address decoder. Qualifies the bus strobes with the peripheral
// select and the alignment bits, and turns a hit write into one enable per
// word. Assumes at most one of wr/rd is high per cycle.
module sumacc_decode #(
    parameter int          ADDR_W = 16,
    parameter int          NWORDS = 4,
    parameter logic [ADDR_W-5:0] BASE = 12'h321
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr,
    input  logic                      rd,
    output logic                      hit,
    output sumacc_pkg::reg_idx_e      idx,
    output logic [NWORDS-1:0]         we_vec,
    output logic                      re_hit
);
    import sumacc_pkg::*;

    localparam int SEL_W = ADDR_W - 4;

    logic [SEL_W-1:0] sel_field;

    // Purpose: split the address into select field and word index.
    always_comb begin
        sel_field = addr[ADDR_W-1:4];
        idx       = reg_idx_e'(addr[3:2]);
        hit       = (sel_field == BASE) && (addr[1:0] == 2'b00);
        re_hit    = rd && hit;
    end

    // Purpose: one write enable per word, generated from the index.
    for (genvar g = 0; g < NWORDS; g++) begin : g_we
        assign we_vec[g] = wr && hit && (addr[3:2] == IDX_W'(g));
    end

    // R1
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    // R1
    miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |-> (we_vec == '0));

endmodule

// File: rtl/sumacc_ctrl.sv
// Module: control/status logic. Holds the control half, detects a rising
// start bit and keeps the done flag. Assumes ctl_we is a single-cycle write.
module sumacc_ctrl #(
    parameter int CTL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic             start,
    output logic             done_q
);

    logic go_prev;

    // Purpose: start pulses for one cycle after control bit 0 rises.
    always_comb begin
        start = ctl_q[0] && !go_prev;
    end

    // Purpose: hold the written control half.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl_q <= '0;
        else if (ctl_we)  ctl_q <= ctl_wdata;
    end

    // Purpose: remember last cycle's start bit for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) go_prev <= 1'b0;
        else        go_prev <= ctl_q[0];
    end

    // Purpose: done flag; a clearing write wins over a start.
    always_ff @(posedge clk) begin
        if (!rst_n)                        done_q <= 1'b0;
        else if (ctl_we && !ctl_wdata[0])  done_q <= 1'b0;
        else if (start)                    done_q <= 1'b1;
    end

    // R5
    done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_q[0]) && !(ctl_we && !ctl_wdata[0])) |=> done_q);

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_wdata[0]) |=> !done_q);

    // R4
    ctl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl_q == $past(ctl_wdata)));

endmodule

// File: rtl/sumacc_datapath.sv
// Module: operand registers and the summing register. The sum loads only
// on a start pulse. Assumes operand enables are one-hot or idle.
module sumacc_datapath #(
    parameter int DATA_W = 32,
    parameter int NOPS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NOPS-1:0]   op_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] sum_q
);

    logic [DATA_W-1:0] opr [NOPS];

    // Purpose: one storage register per operand.
    for (genvar g = 0; g < NOPS; g++) begin : g_op
        always_ff @(posedge clk) begin
            if (!rst_n)        opr[g] <= '0;
            else if (op_we[g]) opr[g] <= wdata;
        end

        // R3
        op_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            op_we[g] |=> (opr[g] == $past(wdata)));
    end

    assign op_a = opr[0];
    assign op_b = opr[1];

    // Purpose: capture the wrapped sum on a start pulse only.
    always_ff @(posedge clk) begin
        if (!rst_n)    sum_q <= '0;
        else if (load) sum_q <= op_a + op_b;
    end

    // R8
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> $stable(sum_q));

endmodule

// File: rtl/sumacc_top.sv
// Module: adder peripheral top. Wires the decoder, control and datapath,
// and registers read data. Assumes one bus access per cycle.
module sumacc_top #(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 32,
    parameter int                CTL_W  = 16,
    parameter logic [ADDR_W-5:0] BASE   = 12'h321
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    import sumacc_pkg::*;

    localparam int NWORDS = 4;
    localparam int NOPS   = 2;
    localparam int STS_W  = DATA_W - CTL_W;

    logic              hit;
    reg_idx_e          idx;
    logic [NWORDS-1:0] we_vec;
    logic              re_hit;
    logic [CTL_W-1:0]  ctl_q;
    logic              start;
    logic              done_q;
    logic [DATA_W-1:0] op_a, op_b, sum_q;
    logic [DATA_W-1:0] csr_word;
    logic [DATA_W-1:0] rd_mux;

    sumacc_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .BASE(BASE)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .hit(hit), .idx(idx), .we_vec(we_vec), .re_hit(re_hit)
    );

    sumacc_ctrl #(.CTL_W(CTL_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_we(we_vec[IDX_CSR]),
        .ctl_wdata(bus_wdata[CTL_W-1:0]), .ctl_q(ctl_q),
        .start(start), .done_q(done_q)
    );

    sumacc_datapath #(.DATA_W(DATA_W), .NOPS(NOPS)) u_dp (
        .clk(clk), .rst_n(rst_n), .op_we(we_vec[NOPS-1:0]), .wdata(bus_wdata),
        .load(start), .op_a(op_a), .op_b(op_b), .sum_q(sum_q)
    );

    // Purpose: pack the status half above the control half.
    always_comb begin
        csr_word = {{(STS_W-1){1'b0}}, done_q, ctl_q};
    end

    // Purpose: select the addressed word for a read.
    always_comb begin
        unique case (idx)
            IDX_OPA: rd_mux = op_a;
            IDX_OPB: rd_mux = op_b;
            IDX_SUM: rd_mux = sum_q;
            default: rd_mux = csr_word;
        endcase
    end

    // Purpose: register read data; a missed read returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (re_hit) bus_rdata <= rd_mux;
        else if (bus_rd) bus_rdata <= '0;
    end

    // R1
    miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> (bus_rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> $stable(bus_rdata));

    // R4
    csr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re_hit && idx == IDX_CSR) |=> (bus_rdata[DATA_W-1:CTL_W+1] == '0));

    // R6
    sum_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_vec[IDX_SUM] && !start) |=> $stable(sum_q));

endmodule

// File: tb/sumacc_top_bench.sv
module sumacc_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    sumacc_top u_sumacc_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] adr(input logic [11:0] base, input logic [1:0] idx);
        return {base, idx, 2'b00};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: queue the expected value, then issue the read strobe
    task automatic rd_chk(input logic [15:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: data is valid on the falling edge after the strobe's edge
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: got %08h expected %08h", t, bus_rdata, e);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    localparam logic [11:0] B = 12'h321;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R2 reset values
        rd_chk(adr(B, 0), 32'h0, "R2 opa");
        rd_chk(adr(B, 1), 32'h0, "R2 opb");
        rd_chk(adr(B, 2), 32'h0, "R2 sum");
        rd_chk(adr(B, 3), 32'h0, "R2 csr");
        // R3 operand load
        wr(adr(B, 0), 32'hAA55A5A5);
        wr(adr(B, 1), 32'h11221212);
        rd_chk(adr(B, 0), 32'hAA55A5A5, "R3 opa");
        rd_chk(adr(B, 1), 32'h11221212, "R3 opb");
        // R4 status half of write data ignored, no start
        wr(adr(B, 3), 32'hABCD0000);
        idle(1);
        rd_chk(adr(B, 3), 32'h0, "R4 csr upper ignored");
        rd_chk(adr(B, 2), 32'h0, "R4 no start");
        // R5 start: the gap cycle shows the old values, then the sum
        wr(adr(B, 3), 32'h00000001);
        rd_chk(adr(B, 3), 32'h00000001, "R5 done not yet");
        rd_chk(adr(B, 3), 32'h00010001, "R5 done set");
        rd_chk(adr(B, 2), 32'hBB77B7B7, "R5 sum");
        // R9 read data holds without a strobe
        idle(2);
        checks++;
        if (bus_rdata !== 32'hBB77B7B7) begin
            errors++;
            $display("FAIL R9 hold: got %08h expected %08h", bus_rdata, 32'hBB77B7B7);
        end
        // R6 sum is read-only
        wr(adr(B, 2), 32'hDEADBEEF);
        rd_chk(adr(B, 2), 32'hBB77B7B7, "R6 sum write ignored");
        // R8 operand write after done
        wr(adr(B, 0), 32'h00000001);
        idle(1);
        rd_chk(adr(B, 2), 32'hBB77B7B7, "R8 sum held");
        // R10 rewriting start bit as 1 starts nothing
        wr(adr(B, 3), 32'h00000001);
        idle(1);
        rd_chk(adr(B, 2), 32'hBB77B7B7, "R10 no restart");
        rd_chk(adr(B, 3), 32'h00010001, "R10 done kept");
        // R7 clear done
        wr(adr(B, 3), 32'h00000000);
        rd_chk(adr(B, 3), 32'h0, "R7 done cleared");
        rd_chk(adr(B, 2), 32'hBB77B7B7, "R8 sum after clear");
        // R5 wrap-around sum
        wr(adr(B, 1), 32'hFFFFFFFF);
        wr(adr(B, 3), 32'h00000001);
        idle(1);
        rd_chk(adr(B, 2), 32'h00000000, "R5 wrap");
        // R7 clear wins over a start on the same edge
        wr(adr(B, 3), 32'h00000000);
        wr(adr(B, 3), 32'h00000001);
        wr(adr(B, 3), 32'h00000000);
        idle(1);
        rd_chk(adr(B, 3), 32'h0, "R7 clear priority");
        // R1 wrong select and misaligned accesses
        wr(adr(12'h320, 0), 32'h5555AAAA);
        wr({B, 2'd1, 2'b01}, 32'h12345678);
        rd_chk(adr(B, 0), 32'h00000001, "R1 miss write opa");
        rd_chk(adr(B, 1), 32'hFFFFFFFF, "R1 misaligned write opb");
        rd_chk(adr(12'h320, 0), 32'h0, "R1 miss read");
        // R2 reset mid-run
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rd_chk(adr(B, 0), 32'h0, "R2 opa after reset");
        rd_chk(adr(B, 1), 32'h0, "R2 opb after reset");
        rd_chk(adr(B, 2), 32'h0, "R2 sum after reset");
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule